// File: doc/BRIEF.md
# Low-Resolution VGA Framebuffer Scan-Out

This block drives a VGA monitor at 800x600, 56 Hz from a small byte-wide framebuffer. Free-running horizontal and vertical counters produce the two sync pulses. A fetch unit reads framebuffer bytes through a simple read port: it places an address on the port and gets the byte back one cycle later. It then maps the low three bits of each byte onto a 3-bit colour output.

The image is deliberately coarse. Each byte stays on the colour output for several system clocks, and each framebuffer row is replayed on three consecutive scan lines. A frame-valid flag gates streaming. The flag rises when the vertical back porch ends and drops once the last row has been replayed, and at that point the read address returns to the start of the buffer. Rows are stored at a stride equal to the visible byte count plus three padding bytes. Every streamed line fetches the whole stride, padding included.

All timing is given in system clocks. The defaults suit a 72 MHz clock at two clocks per pixel, which gives a 2048-clock line and a 625-line frame.

Top module: `lrv_scanout`

## Requirements
- R1: `hsync_o` is low for exactly H_SYNC clocks and high for the remaining clocks of every H_SYNC+H_BP+H_VIS+H_FP clock line.
- R2: `vsync_o` is high for the first V_SYNC lines and low for the remaining lines of every V_SYNC+V_BP+V_VIS+V_FP line frame. It changes only at line boundaries, in step with the hsync falling edge.
- R3: While `rst_ni` is low, `hsync_o` is 1, `vsync_o` is 0, `rgb_o` is 0 and `rd_addr_o` is 0. After release the line and frame counters start from zero, so the first line is a sync line.
- R4: Nothing is streamed in the vertical sync and back-porch lines. Streaming begins on line V_SYNC+V_BP, the line after the frame-valid flag is raised.
- R5: On a streamed line, colour output starts H_SYNC+H_BP clocks after the hsync falling edge.
- R6: Each line streams ROW_BYTES+3 bytes. Each byte stays on `rgb_o` for HOLD clocks, and `rd_addr_o` stays steady while a byte is held.
- R7: Each framebuffer row is output on three consecutive lines. Byte b of row r is read from address r*(ROW_BYTES+3)+b.
- R8: After the third line of row ROWS-1, the row and repeat counters and the frame-valid flag clear. The next frame streams again from address 0.
- R9: Colour bit 0 is red, bit 1 is green and bit 2 is blue. They come from bits 0, 1 and 2 of the fetched byte, and bits 7..3 have no effect.
- R10: `rgb_o` is 0 whenever no byte is being streamed. This covers horizontal blanking, the clocks after the last byte and the lines after the last row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_addr_o | output | AW | Framebuffer read address |
| rd_data_i | input | 8 | Framebuffer byte, valid one cycle after its address |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active high |
| rgb_o | output | 3 | Colour: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The assertions watch on every cycle where the sync edges fall against the counters, that the address holds steady within a byte, that streaming only starts on a line-start event while the frame is valid, and that the row state is clear when the frame-valid flag drops. Only the bench's sweeps can show the cycle-exact picture: which lines carry data, which framebuffer byte appears at each clock, the three-fold row replay, and the restart of the image on later frames and after a reset mid-frame. The bench memory holds bytes with non-zero upper bits, so the colour mapping is exercised on every streamed clock.

// File: rtl/lrv_pkg.sv
package lrv_pkg;
  localparam int unsigned RGB_W = 3;
  typedef logic [RGB_W-1:0] rgb_t;

  // bit0 red, bit1 green, bit2 blue; upper byte bits are don't-care
  function automatic rgb_t byte_to_rgb(input logic [7:0] b);
    return b[RGB_W-1:0];
  endfunction
endpackage

// File: rtl/lrv_hgen.sv
module lrv_hgen #(
  parameter int unsigned H_SYNC = 144,
  parameter int unsigned H_BP   = 256,
  parameter int unsigned H_VIS  = 1600,
  parameter int unsigned H_FP   = 48
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic hsync_o,
  output logic line_end_o,
  output logic stream_go_o
);
  localparam int unsigned H_TOTAL = H_SYNC + H_BP + H_VIS + H_FP;
  localparam int unsigned HW      = $clog2(H_TOTAL);

  logic [HW-1:0] hcnt_q;

  assign line_end_o  = (hcnt_q == HW'(H_TOTAL - 1));
  assign stream_go_o = (hcnt_q == HW'(H_SYNC + H_BP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hcnt_q  <= '0;
      hsync_o <= 1'b1;
    end else begin
      hcnt_q  <= line_end_o ? '0 : hcnt_q + 1'b1;
      hsync_o <= !(hcnt_q < HW'(H_SYNC));
    end
  end

  // R1
  hsync_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hsync_o) |-> hcnt_q == HW'(1));
  // R1
  hsync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hsync_o) |-> hcnt_q == HW'(H_SYNC + 1));
endmodule

// File: rtl/lrv_vgen.sv
module lrv_vgen #(
  parameter int unsigned V_SYNC = 2,
  parameter int unsigned V_BP   = 22,
  parameter int unsigned V_VIS  = 600,
  parameter int unsigned V_FP   = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_end_i,
  output logic vsync_o,
  output logic frame_go_o
);
  localparam int unsigned V_TOTAL = V_SYNC + V_BP + V_VIS + V_FP;
  localparam int unsigned VW      = $clog2(V_TOTAL);

  logic [VW-1:0] vcnt_q;

  // end of vertical back porch
  assign frame_go_o = line_end_i && (vcnt_q == VW'(V_SYNC + V_BP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vcnt_q  <= '0;
      vsync_o <= 1'b0;
    end else begin
      if (line_end_i) vcnt_q <= (vcnt_q == VW'(V_TOTAL - 1)) ? '0 : vcnt_q + 1'b1;
      vsync_o <= (vcnt_q < VW'(V_SYNC));
    end
  end

  // R2
  vsync_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vsync_o) |-> vcnt_q == '0);
  // R2
  vsync_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vsync_o) |-> vcnt_q == VW'(V_SYNC));
endmodule

// File: rtl/lrv_fetch.sv
module lrv_fetch
  import lrv_pkg::*;
#(
  parameter int unsigned ROW_BYTES = 64,
  parameter int unsigned ROWS      = 32,
  parameter int unsigned HOLD      = 9,
  parameter int unsigned REP       = 3,
  parameter int unsigned AW        = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stream_go_i,
  input  logic          frame_go_i,
  input  logic [7:0]    rd_data_i,
  output logic [AW-1:0] addr_o,
  output rgb_t          rgb_o
);
  localparam int unsigned STRIDE = ROW_BYTES + 3;
  localparam int unsigned BW     = $clog2(STRIDE + 1);
  localparam int unsigned KW     = $clog2(HOLD + 1);
  localparam int unsigned PW     = $clog2(REP + 1);
  localparam int unsigned RW     = $clog2(ROWS + 1);

  logic          fv_q, busy_q, busy_d_q;
  logic [BW-1:0] bcnt_q;
  logic [KW-1:0] hold_q;
  logic [PW-1:0] rep_q;
  logic [RW-1:0] row_q;
  logic [AW-1:0] base_q;
  logic          hold_last, byte_last, line_done, rep_last, row_last;

  assign hold_last = (hold_q == KW'(HOLD - 1));
  assign byte_last = (bcnt_q == BW'(STRIDE - 1));
  assign line_done = busy_q && hold_last && byte_last;
  assign rep_last  = (rep_q == PW'(REP - 1));
  assign row_last  = (row_q == RW'(ROWS - 1));

  assign addr_o = base_q + AW'(bcnt_q);
  assign rgb_o  = busy_d_q ? byte_to_rgb(rd_data_i) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fv_q     <= 1'b0;
      busy_q   <= 1'b0;
      busy_d_q <= 1'b0;
      bcnt_q   <= '0;
      hold_q   <= '0;
      rep_q    <= '0;
      row_q    <= '0;
      base_q   <= '0;
    end else begin
      busy_d_q <= busy_q;
      if (busy_q) begin
        if (hold_last) begin
          hold_q <= '0;
          if (byte_last) begin
            busy_q <= 1'b0;
            bcnt_q <= '0;
          end else begin
            bcnt_q <= bcnt_q + 1'b1;
          end
        end else begin
          hold_q <= hold_q + 1'b1;
        end
      end else if (stream_go_i && fv_q) begin
        busy_q <= 1'b1;
        bcnt_q <= '0;
        hold_q <= '0;
      end

      if (line_done) begin
        if (rep_last) begin
          rep_q <= '0;
          if (row_last) begin
            row_q  <= '0;
            base_q <= '0;
            fv_q   <= 1'b0;
          end else begin
            row_q  <= row_q + 1'b1;
            base_q <= base_q + AW'(STRIDE);
          end
        end else begin
          rep_q <= rep_q + 1'b1;
        end
      end
      if (frame_go_i) fv_q <= 1'b1;
    end
  end

  // R6
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !hold_last |=> $stable(addr_o));
  // R4
  idle_no_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fv_q |-> !busy_q);
  // R5
  start_on_go_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(stream_go_i) && addr_o == base_q);
  // R7
  row_repeat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_done && !rep_last |=> $stable(base_q));
  // R8
  frame_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fv_q) |-> row_q == '0 && rep_q == '0 && base_q == '0);
endmodule

// File: rtl/lrv_scanout.sv
module lrv_scanout
  import lrv_pkg::*;
#(
  parameter int unsigned H_SYNC    = 144,
  parameter int unsigned H_BP      = 256,
  parameter int unsigned H_VIS     = 1600,
  parameter int unsigned H_FP      = 48,
  parameter int unsigned V_SYNC    = 2,
  parameter int unsigned V_BP      = 22,
  parameter int unsigned V_VIS     = 600,
  parameter int unsigned V_FP      = 1,
  parameter int unsigned ROW_BYTES = 64,
  parameter int unsigned ROWS      = 32,
  parameter int unsigned HOLD      = 9,
  parameter int unsigned AW        = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] rd_addr_o,
  input  logic [7:0]    rd_data_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic [2:0]    rgb_o
);
  localparam int unsigned REP = 3;

  logic line_end, stream_go, frame_go;
  rgb_t rgb;

  lrv_hgen #(.H_SYNC(H_SYNC), .H_BP(H_BP), .H_VIS(H_VIS), .H_FP(H_FP)) u_hgen (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hsync_o     (hsync_o),
    .line_end_o  (line_end),
    .stream_go_o (stream_go)
  );

  lrv_vgen #(.V_SYNC(V_SYNC), .V_BP(V_BP), .V_VIS(V_VIS), .V_FP(V_FP)) u_vgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_end_i (line_end),
    .vsync_o    (vsync_o),
    .frame_go_o (frame_go)
  );

  lrv_fetch #(.ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .HOLD(HOLD), .REP(REP), .AW(AW)) u_fetch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stream_go_i (stream_go),
    .frame_go_i  (frame_go),
    .rd_data_i   (rd_data_i),
    .addr_o      (rd_addr_o),
    .rgb_o       (rgb)
  );

  assign rgb_o = rgb;
endmodule

// File: tb/tb_lrv_scanout.sv
module tb_lrv_scanout;
  localparam int H_SYNC = 4, H_BP = 6, H_VIS = 40, H_FP = 4;
  localparam int V_SYNC = 2, V_BP = 3, V_VIS = 12, V_FP = 1;
  localparam int ROW_BYTES = 3, ROWS = 4, HOLD = 3, AW = 8;
  localparam int HT = H_SYNC + H_BP + H_VIS + H_FP;
  localparam int VT = V_SYNC + V_BP + V_VIS + V_FP;
  localparam int FRAME = HT * VT;
  localparam int STRIDE = ROW_BYTES + 3;
  localparam int H_START = H_SYNC + H_BP;
  localparam int V_START = V_SYNC + V_BP;
  localparam int MEM_N = ROWS * STRIDE;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] rd_addr;
  logic [7:0] rd_data = 8'h00;
  logic hsync, vsync;
  logic [2:0] rgb;
  logic [7:0] mem [MEM_N];
  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lrv_scanout #(
    .H_SYNC(H_SYNC), .H_BP(H_BP), .H_VIS(H_VIS), .H_FP(H_FP),
    .V_SYNC(V_SYNC), .V_BP(V_BP), .V_VIS(V_VIS), .V_FP(V_FP),
    .ROW_BYTES(ROW_BYTES), .ROWS(ROWS), .HOLD(HOLD), .AW(AW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .hsync_o(hsync), .vsync_o(vsync), .rgb_o(rgb)
  );

  always @(posedge clk) rd_data <= (int'(rd_addr) < MEM_N) ? mem[int'(rd_addr)] : 8'hFF;

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_reset();
    check("R3 hsync", int'(hsync), 1);
    check("R3 vsync", int'(vsync), 0);
    check("R3 rgb", int'(rgb), 0);
    check("R3 addr", int'(rd_addr), 0);
  endtask

  function automatic bit streamed(input int l, input int h);
    return l >= V_START && l < V_START + 3 * ROWS && h >= H_START && h < H_START + STRIDE * HOLD;
  endfunction

  // n = edges since reset release; outputs reflect phase p = n-1
  task automatic check_cycle(input int n);
    int p = n - 1;
    int hp = p % HT, lp = (p / HT) % VT, fr = p / FRAME;
    int hn = n % HT, ln = (n / HT) % VT;
    int row, exp_rgb;
    string tag;
    check("R1 hsync", int'(hsync), (hp < H_SYNC) ? 0 : 1);
    check("R2 vsync", int'(vsync), (lp < V_SYNC) ? 1 : 0);
    if (streamed(lp, hp)) begin
      row = (lp - V_START) / 3;
      exp_rgb = int'(mem[row * STRIDE + (hp - H_START) / HOLD][2:0]);
      if (hp == H_START) tag = "R5 rgb start";
      else if (row == 0 && fr > 0) tag = "R8 rgb after wrap";
      else if ((lp - V_START) % 3 != 0) tag = "R7 rgb repeat";
      else if ((hp - H_START) % HOLD != 0) tag = "R6 rgb hold";
      else tag = "R9 rgb map";
    end else begin
      exp_rgb = 0;
      tag = (lp < V_START) ? "R4 rgb vblank" : "R10 rgb idle";
    end
    check(tag, int'(rgb), exp_rgb);
    if (streamed(ln, hn))
      check("R6 addr", int'(rd_addr), ((ln - V_START) / 3) * STRIDE + (hn - H_START) / HOLD);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    for (int i = 0; i < MEM_N; i++) mem[i] = 8'(i * 37 + 11);
    repeat (3) @(negedge clk);
    check_reset();
    rst_ni = 1'b1;
    for (int n = 1; n <= 3 * FRAME + 10; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(n);
    end
    // asynchronous reset mid-frame, then restart from zero
    repeat (7 * HT + 13) @(negedge clk);
    rst_ni = 1'b0;
    #1;
    check_reset();
    repeat (3) @(negedge clk);
    check_reset();
    rst_ni = 1'b1;
    for (int n = 1; n <= FRAME + 5; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_cycle(n);
    end
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule